// File: doc/BRIEF.md
# Multiprocessor Asynchronous Serial Port

This block is a full-duplex asynchronous serial port. Software configures it, queues characters and collects received ones through a small register port. Each direction has its own eight-entry FIFO. A character is framed by a low start bit, 8 or 9 data bits sent least significant bit first, an optional parity bit, and one or two high stop bits. Bit timing comes from an external divider. That divider supplies a `baud_tick` strobe at sixteen times the bit rate, and every bit lasts sixteen strobes.

For bus setups with several listeners, the port supports address-wake filtering. The ninth data bit marks an address character (1) or a data character (0). With the filter on, the receiver keeps only address characters, so a listener is not disturbed by traffic meant for other nodes. The receiver flags parity, framing and overrun errors in sticky flags that are cleared by writing ones. Four interrupt lines report a drained transmit queue, the end of each sent frame, each stored character, and any pending error. A loop-back switch feeds the transmitter into the receiver and holds the pin high, which lets the port be tested on its own.

Register map (`addr`). The register read data (`rd_data`) is combinational on `addr`:
- 0 is configuration: bit0 nine-bit data, bit1 parity on, bit2 odd parity, bit3 two stop bits, bit4 wake filter, bit5 loop-back.
- 1 is the transmit write register: bits [8:0] are pushed to the transmit FIFO.
- 2 is the receive read register: bits [8:0] hold the head character, and a read pops it.
- 3 is status: bit0 parity error, bit1 framing error, bit2 overrun, bit3 transmitter busy, bits [7:4] transmit FIFO count, bits [11:8] receive FIFO count. Writing ones to bits [2:0] clears those flags.

Top module: `mpser_port`

## Requirements
- R1: After reset, `txd` is 1, `irq_tx_empty` is 1, `irq_err` is 0, and the configuration and status registers read 0.
- R2: A queued character leaves `txd` as one low start bit, then the data bits least significant first (8 bits, or 9 when configuration bit0 is set), then the optional parity bit, then one stop bit (two when bit3 is set). Each bit is held for 16 `baud_tick` strobes.
- R3: With parity on, the parity bit equals the XOR of the data bits, inverted when configuration bit2 (odd) is set.
- R4: A correctly framed character on the receive line is placed in the receive FIFO, with bit 8 read as 0 in 8-bit mode, and `irq_rx` pulses once per stored character.
- R5: A stored character whose parity bit disagrees with the parity rule sets status bit0.
- R6: A character whose first stop bit is sampled low sets status bit1 and is still stored.
- R7: A character that completes while the receive FIFO holds eight entries is dropped and sets status bit2, and the eight stored entries are kept.
- R8: With nine-bit mode and the wake filter both on, a character whose ninth bit is 0 is discarded: it is not stored and raises no `irq_rx` and no error flag.
- R9: In loop-back mode, the receiver takes the transmitter's line, and `txd` stays 1.
- R10: `irq_tx_done` pulses for one cycle after the last stop bit of each frame. `irq_tx_empty` is 1 exactly when the transmit FIFO is empty.
- R11: Error flags stay set until a status write clears them with ones in bits [2:0]. `irq_err` is 1 while any flag is set.
- R12: A low pulse on the receive line shorter than half a bit period is rejected as a start bit and stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | Strobe at 16 times the bit rate |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (pops the receive FIFO at address 2) |
| addr | input | 2 | Register address |
| wr_data | input | 16 | Register write data |
| rd_data | output | 16 | Register read data |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq_tx_empty | output | 1 | Transmit FIFO empty |
| irq_tx_done | output | 1 | Last bit of a frame sent |
| irq_rx | output | 1 | Character stored |
| irq_err | output | 1 | Any error flag set |

## Verification
Every cycle, the assertions check that `txd` stays high in loop-back and that the frame-end interrupt lasts only one cycle. They also check that every receive interrupt adds exactly one FIFO entry, that the receive count never passes its depth, and that no error flag drops without a matching clear write. Other behaviour only shows across whole frames, so only the bench scenarios can show it. This covers the bit order and parity value on the line for each framing choice, and the data that comes back through loop-back. It also covers which flags a corrupted frame sets, the rejection of a short start glitch, the discarding of data characters by the wake filter, and the keeping of the first eight characters on overrun.

// File: rtl/mps_pkg.sv
// Shared types for the multiprocessor serial port.
// Assumes: configuration register layout is fixed by the cfg_t field order.
package mps_pkg;

    // Register addresses of the host port
    typedef enum logic [1:0] {
        A_CFG  = 2'd0,
        A_TXW  = 2'd1,
        A_RXR  = 2'd2,
        A_STAT = 2'd3
    } reg_addr_e;

    // Configuration bits; first field is the most significant (bit5)
    typedef struct packed {
        logic loopback;   // bit5
        logic wake_filt;  // bit4
        logic two_stop;   // bit3
        logic par_odd;    // bit2
        logic par_en;     // bit1
        logic nine_bit;   // bit0
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    // Receiver sequencing
    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP,
        RX_REARM
    } rx_state_e;

endpackage

// File: rtl/mps_fifo.sv
// Synchronous first-in first-out store.
// Assumes: DEPTH is a power of two; push on full and pop on empty are ignored.
module mps_fifo #(
    parameter int W     = 9,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               dout,
    output logic                       empty,
    output logic                       full,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          push_ok, pop_ok;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign dout    = mem[rd_ptr];

    // Storage write
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
            if (push_ok && !pop_ok)      count <= count + 1'b1;
            else if (pop_ok && !push_ok) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/mps_tx.sv
// Frame transmitter: takes one character from the queue when idle, builds the
// whole frame, and shifts it out one bit per OVS ticks, least significant first.
// Assumes: configuration is sampled at frame load; line idles high.
module mps_tx
    import mps_pkg::*;
#(
    parameter int DW  = 9,
    parameter int OVS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  cfg_t          cfg,
    input  logic          q_empty,
    input  logic [DW-1:0] q_data,
    output logic          q_pop,
    output logic          line,
    output logic          busy,
    output logic          done
);
    localparam int FW = DW + 4;             // start + data + parity + two stops
    localparam int LW = $clog2(FW + 1);
    localparam int OW = $clog2(OVS);
    localparam int IW = $clog2(DW + 1);

    logic [FW-1:0] frame, shreg;
    logic [LW-1:0] len, left;
    logic [OW-1:0] cnt;
    logic [IW-1:0] nd;
    logic [DW-1:0] dmask;
    logic          pbit;

    assign nd    = cfg.nine_bit ? IW'(DW) : IW'(DW - 1);
    assign dmask = cfg.nine_bit ? q_data : {1'b0, q_data[DW-2:0]};
    assign pbit  = (^dmask) ^ cfg.par_odd;
    assign q_pop = !busy && !q_empty;
    assign line  = busy ? shreg[0] : 1'b1;

    // Frame assembly from the queue head and configuration
    always_comb begin
        frame    = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < DW; i++) begin
            if (i < int'(nd)) frame[1+i] = q_data[i];
        end
        if (cfg.par_en) frame[LW'(nd) + LW'(1)] = pbit;
        len = LW'(1) + LW'(nd) + (cfg.par_en ? LW'(1) : LW'(0))
            + (cfg.two_stop ? LW'(2) : LW'(1));
    end

    // Bit timing and shifting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            shreg <= '1;
            left  <= '0;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (!q_empty) begin
                    shreg <= frame;
                    left  <= len;
                    cnt   <= '0;
                    busy  <= 1'b1;
                end
            end else if (tick) begin
                if (cnt == OW'(OVS - 1)) begin
                    cnt   <= '0;
                    shreg <= {1'b1, shreg[FW-1:1]};
                    left  <= left - 1'b1;
                    if (left == LW'(1)) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/mps_rx.sv
// Frame receiver: synchronises the line, qualifies the start bit at mid-bit,
// samples each following bit at its centre and reports the character with its
// parity and stop-bit checks for one cycle.
// Assumes: tick runs at OVS times the bit rate; only the first stop bit is checked.
module mps_rx
    import mps_pkg::*;
#(
    parameter int DW  = 9,
    parameter int OVS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  cfg_t          cfg,
    input  logic          line_in,
    output logic          done,
    output logic [DW-1:0] word,
    output logic          par_err,
    output logic          frm_err
);
    localparam int OW = $clog2(OVS);
    localparam int IW = $clog2(DW + 1);

    rx_state_e     st;
    logic [OW-1:0] cnt;
    logic [IW-1:0] idx, nd;
    logic          s1, s2, pbit, centre;

    assign nd     = cfg.nine_bit ? IW'(DW) : IW'(DW - 1);
    assign centre = tick && (cnt == OW'(OVS - 1));

    // Two-stage line synchroniser, idles high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
        end else begin
            s1 <= line_in;
            s2 <= s1;
        end
    end

    // Receive sequencing, bit sampling and checks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= RX_IDLE;
            cnt     <= '0;
            idx     <= '0;
            word    <= '0;
            pbit    <= 1'b0;
            done    <= 1'b0;
            par_err <= 1'b0;
            frm_err <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (st)
                RX_IDLE: begin
                    if (tick && !s2) begin
                        st  <= RX_START;
                        cnt <= '0;
                    end
                end
                RX_START: begin
                    if (tick) begin
                        if (cnt == OW'(OVS / 2 - 1)) begin
                            cnt <= '0;
                            if (!s2) begin
                                st   <= RX_DATA;
                                idx  <= '0;
                                word <= '0;
                            end else begin
                                st <= RX_IDLE;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                RX_DATA: begin
                    if (centre) begin
                        cnt       <= '0;
                        word[idx] <= s2;
                        if (idx == nd - 1'b1) st <= cfg.par_en ? RX_PAR : RX_STOP;
                        else                  idx <= idx + 1'b1;
                    end else if (tick) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_PAR: begin
                    if (centre) begin
                        cnt  <= '0;
                        pbit <= s2;
                        st   <= RX_STOP;
                    end else if (tick) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (centre) begin
                        cnt     <= '0;
                        done    <= 1'b1;
                        frm_err <= !s2;
                        par_err <= cfg.par_en && (pbit != ((^word) ^ cfg.par_odd));
                        st      <= s2 ? RX_IDLE : RX_REARM;
                    end else if (tick) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_REARM: begin
                    if (s2) st <= RX_IDLE;
                end
                default: st <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mpser_port.sv
// Full-duplex asynchronous serial port with address-wake filtering.
// Holds the configuration and the sticky error flags, routes loop-back, and
// decides per received character whether to store, discard or flag overrun.
// Assumes: register reads are combinational; a read of address 2 pops.
module mpser_port
    import mps_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int OVS   = 16,
    parameter int DW    = 9,
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             baud_tick,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [1:0]       addr,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             rxd,
    output logic             txd,
    output logic             irq_tx_empty,
    output logic             irq_tx_done,
    output logic             irq_rx,
    output logic             irq_err
);
    localparam int CW = $clog2(DEPTH + 1);

    cfg_t          cfg_q;
    logic [2:0]    err_q;
    logic          tx_push, tx_pop, tx_empty, tx_full, tx_busy, tx_line;
    logic [DW-1:0] tx_head, rx_head, rx_word;
    logic [CW-1:0] tx_cnt, rx_cnt;
    logic          rx_push, rx_pop, rx_empty, rx_full;
    logic          rx_done, rx_perr, rx_ferr, rx_keep, rx_ovr;
    logic          stat_wr;

    assign tx_push = wr_en && (addr == A_TXW);
    assign rx_pop  = rd_en && (addr == A_RXR);
    assign stat_wr = wr_en && (addr == A_STAT);

    // Character acceptance: wake filter drops data characters in nine-bit mode
    assign rx_keep = rx_done && !(cfg_q.wake_filt && cfg_q.nine_bit && !rx_word[DW-1]);
    assign rx_push = rx_keep && !rx_full;
    assign rx_ovr  = rx_keep && rx_full;

    assign txd          = cfg_q.loopback ? 1'b1 : tx_line;
    assign irq_tx_empty = tx_empty;
    assign irq_rx       = rx_push;
    assign irq_err      = |err_q;

    mps_fifo #(.W(DW), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push(tx_push), .din(wr_data[DW-1:0]),
        .pop(tx_pop), .dout(tx_head),
        .empty(tx_empty), .full(tx_full), .count(tx_cnt)
    );

    mps_tx #(.DW(DW), .OVS(OVS)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(baud_tick), .cfg(cfg_q),
        .q_empty(tx_empty), .q_data(tx_head), .q_pop(tx_pop),
        .line(tx_line), .busy(tx_busy), .done(irq_tx_done)
    );

    mps_rx #(.DW(DW), .OVS(OVS)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(baud_tick), .cfg(cfg_q),
        .line_in(cfg_q.loopback ? tx_line : rxd),
        .done(rx_done), .word(rx_word), .par_err(rx_perr), .frm_err(rx_ferr)
    );

    mps_fifo #(.W(DW), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .din(rx_word),
        .pop(rx_pop), .dout(rx_head),
        .empty(rx_empty), .full(rx_full), .count(rx_cnt)
    );

    // Configuration register
    always_ff @(posedge clk) begin
        if (!rst_n)                             cfg_q <= '0;
        else if (wr_en && (addr == A_CFG))      cfg_q <= cfg_t'(wr_data[CFG_W-1:0]);
    end

    // Sticky error flags: clear by writing ones, new events win
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= '0;
        end else begin
            err_q <= (err_q & ~(stat_wr ? wr_data[2:0] : 3'b000))
                   | {rx_ovr, rx_keep && rx_ferr, rx_keep && rx_perr};
        end
    end

    // Register read multiplexer
    always_comb begin
        rd_data = '0;
        unique case (addr)
            A_CFG:  rd_data[CFG_W-1:0] = cfg_q;
            A_RXR:  rd_data[DW-1:0]    = rx_empty ? '0 : rx_head;
            A_STAT: begin
                rd_data[2:0]     = err_q;
                rd_data[3]       = tx_busy;
                rd_data[4 +: CW] = tx_cnt;
                rd_data[8 +: CW] = rx_cnt;
            end
            default: rd_data = '0;
        endcase
    end

    logic unused_ok;
    assign unused_ok = &{1'b0, tx_full, wr_data};
endmodule

// File: rtl/mpser_port_chk.sv
// Property checker for mpser_port, attached by bind below.
// Assumes: signal names of the bound instance as listed in the bind.
module mpser_port_chk
    import mps_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int REG_W = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       txd,
    input cfg_t                       cfg_q,
    input logic                       irq_tx_done,
    input logic                       irq_rx,
    input logic                       rx_pop,
    input logic [$clog2(DEPTH+1)-1:0] rx_cnt,
    input logic [2:0]                 err_q,
    input logic                       wr_en,
    input logic [1:0]                 addr,
    input logic [REG_W-1:0]           wr_data
);
    logic [2:0] hold;
    assign hold = err_q & ~((wr_en && addr == 2'd3) ? wr_data[2:0] : 3'b000);

    // R9
    lpbk_txd_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.loopback |-> txd);

    // R10
    done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx_done |=> !irq_tx_done);

    // R4
    rx_push_counts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_rx && !rx_pop) |=> (int'(rx_cnt) == int'($past(rx_cnt)) + 1));

    // R7
    rx_depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(rx_cnt) <= DEPTH);

    // R11
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((err_q & $past(hold)) == $past(hold)));
endmodule

bind mpser_port mpser_port_chk #(.DEPTH(DEPTH), .REG_W(REG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .txd(txd), .cfg_q(cfg_q),
    .irq_tx_done(irq_tx_done), .irq_rx(irq_rx), .rx_pop(rx_pop),
    .rx_cnt(rx_cnt), .err_q(err_q), .wr_en(wr_en), .addr(addr), .wr_data(wr_data)
);

// File: tb/sim_mpser_port.sv
// Bench: sweeps all framing choices on the pin and through loop-back, then
// drives corrupted frames, a start glitch, wake filtering and overrun.
module sim_mpser_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        baud_tick = 1'b1;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0]  addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        rxd = 1'b1;
    logic        txd, irq_tx_empty, irq_tx_done, irq_rx, irq_err;

    int n_cmp = 0, n_bad = 0;
    int done_pulses = 0, rx_pulses = 0, lb_low = 0;
    logic lb_on = 1'b0;
    logic finished = 1'b0;

    always #5 clk = ~clk;

    mpser_port u0 (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .rxd(rxd), .txd(txd),
        .irq_tx_empty(irq_tx_empty), .irq_tx_done(irq_tx_done),
        .irq_rx(irq_rx), .irq_err(irq_err)
    );

    // Interrupt and pin monitors, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (irq_tx_done) done_pulses++;
            if (irq_rx) rx_pulses++;
            if (lb_on && !txd) lb_low++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; addr = a[1:0]; wr_data = d[15:0];
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        rd_en = 1'b1; addr = a[1:0];
        #1 d = int'(rd_data);
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Expected line frame for a configuration (bits 3:0) and a character
    task automatic exp_frame(input int c, input int d, output logic [15:0] v, output int n);
        int nd, dd;
        nd = c[0] ? 9 : 8;
        dd = c[0] ? (d & 'h1FF) : (d & 'hFF);
        v = '1;
        v[0] = 1'b0;
        for (int i = 0; i < nd; i++) v[1+i] = dd[i];
        n = 1 + nd;
        if (c[1]) begin
            v[n] = logic'(($countones(dd) % 2) ^ c[2]);
            n++;
        end
        n += c[3] ? 2 : 1;
    endtask

    // Capture n bits from txd at bit centres
    task automatic grab_tx(input int n, output logic [15:0] v);
        int guard;
        v = '1;
        guard = 0;
        while (txd && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        repeat (8) @(negedge clk);
        for (int k = 0; k < n; k++) begin
            v[k] = txd;
            if (k < n - 1) repeat (16) @(negedge clk);
        end
    endtask

    // Drive n bits on rxd, 16 clocks each, then idle high
    task automatic drive_rx(input logic [15:0] v, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            rxd = v[k];
            repeat (15) @(negedge clk);
        end
        @(negedge clk);
        rxd = 1'b1;
    endtask

    initial begin
        int r, n, c, d, exp_d, p0, q0;
        logic [15:0] fv, gv;
        int vals[8];

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 txd idle", int'(txd), 1);
        chk("R1 tx empty irq", int'(irq_tx_empty), 1);
        chk("R1 err irq", int'(irq_err), 0);
        rd(0, r); chk("R1 cfg", r, 0);
        rd(3, r); chk("R1 status", r, 0);

        // R2 R3 R10: line frames for every framing choice, two characters each
        for (int cf = 0; cf < 16; cf++) begin
            for (int k = 0; k < 2; k++) begin
                d = (cf * 37 + k * 'h9B + 'h15) & 'h1FF;
                wr(0, cf);
                p0 = done_pulses;
                wr(1, d);
                chk("R10 tx empty low after write", int'(irq_tx_empty), 0);
                exp_frame(cf, d, fv, n);
                grab_tx(n, gv);
                chk($sformatf("R2 R3 frame cfg=%0d", cf),
                    int'(gv & ((16'd1 << n) - 1)), int'(fv & ((16'd1 << n) - 1)));
                idle(24);
                chk("R10 one done pulse per frame", done_pulses - p0, 1);
                chk("R10 tx empty after frame", int'(irq_tx_empty), 1);
            end
        end

        // R4 R9: loop-back round trip for every framing choice
        lb_on = 1'b1;
        q0 = rx_pulses;
        for (int cf = 0; cf < 16; cf++) begin
            for (int k = 0; k < 2; k++) begin
                d = (cf * 53 + k * 'h17F + 'h2A) & 'h1FF;
                exp_d = cf[0] ? d : (d & 'hFF);
                wr(0, cf | 32);
                wr(1, d);
                idle(232);
                rd(3, r);
                chk("R4 one stored, no errors", r & 'hF07, 'h100);
                rd(2, r);
                chk($sformatf("R4 loop data cfg=%0d", cf), r, exp_d);
            end
        end
        chk("R4 irq_rx per character", rx_pulses - q0, 32);
        chk("R9 txd held high in loop-back", lb_low, 0);
        lb_on = 1'b0;

        // R5 R11: parity error from the pin (8 data 0x0F, even parity should be 0)
        wr(0, 'h02);
        fv = '1; fv[0] = 1'b0; fv[8:1] = 8'h0F; fv[9] = 1'b1; fv[10] = 1'b1;
        drive_rx(fv, 11);
        idle(20);
        rd(3, r);
        chk("R5 parity flag only", r & 'h7, 'h1);
        chk("R11 irq_err with flag", int'(irq_err), 1);
        rd(2, r);
        chk("R5 char still stored", r, 'h0F);
        wr(3, 'h2);
        rd(3, r);
        chk("R11 clear of other bit keeps flag", r & 'h7, 'h1);
        wr(3, 'h1);
        rd(3, r);
        chk("R11 cleared by write-one", r & 'h7, 0);
        chk("R11 irq_err low", int'(irq_err), 0);

        // R6: first stop bit low
        wr(0, 'h00);
        fv = '1; fv[0] = 1'b0; fv[8:1] = 8'h3C; fv[9] = 1'b0;
        drive_rx(fv, 10);
        idle(40);
        rd(3, r);
        chk("R6 framing flag, one stored", r & 'hF07, 'h102);
        rd(2, r);
        chk("R6 data kept", r, 'h3C);
        wr(3, 'h7);

        // R12: short low glitch is not a start bit
        q0 = rx_pulses;
        @(negedge clk); rxd = 1'b0;
        repeat (5) @(negedge clk);
        rxd = 1'b1;
        idle(200);
        rd(3, r);
        chk("R12 nothing stored after glitch", r & 'hF07, 0);
        chk("R12 no irq_rx after glitch", rx_pulses - q0, 0);

        // R8: wake filter keeps only address characters
        q0 = rx_pulses;
        wr(0, 'h31);
        wr(1, 'h012); wr(1, 'h155); wr(1, 'h033);
        idle(3 * 11 * 16 + 60);
        rd(3, r);
        chk("R8 only address stored, no flags", r & 'hF07, 'h100);
        chk("R8 one irq_rx", rx_pulses - q0, 1);
        rd(2, r);
        chk("R8 address value", r, 'h155);

        // R7: overrun on the ninth character
        wr(0, 'h20);
        for (int k = 0; k < 8; k++) begin
            vals[k] = (k * 29 + 7) & 'hFF;
            wr(1, vals[k]);
        end
        idle(8 * 10 * 16 + 80);
        rd(3, r);
        chk("R7 eight stored, no overrun", r & 'hF07, 'h800);
        wr(1, 'hEE);
        idle(200);
        rd(3, r);
        chk("R7 overrun flag, count stays eight", r & 'hF07, 'h804);
        for (int k = 0; k < 8; k++) begin
            rd(2, r);
            chk($sformatf("R7 kept entry %0d", k), r, vals[k]);
        end
        rd(3, r);
        chk("R7 queue drained", (r >> 8) & 'hF, 0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule